// File: doc/BRIEF.md
# Synchronized Power-Down Clock Sequencer

This block turns an asynchronous, active-low power-down request into an ordered shutdown and restart of a clock generator's output gates and oscillators. The request is first brought into the internal CPU clock domain through a flop synchronizer. Once it acts, the gate for the core clock group (CPU, 66 MHz and PCI outputs) closes on a falling edge, so the gated clock stops low without a runt pulse. The gate for the free-running reference group closes only while that clock is in its low phase, which can take several cycles.

When both gates are closed and a fixed gate latency has passed, the VCO enable drops, and the crystal enable drops one cycle later. When the request is released, the sequence runs the other way. The crystal enable rises first and the VCO enable follows one cycle later. A programmable stabilization count then runs, and only after it does the core gate reopen. A release that arrives partway through a shutdown does not cut it short: the shutdown finishes, and the restart starts from the sleep state.

The block models the reference group as an internal divided square wave of the CPU clock. It brings out the gated core clock and the gated reference clock, so that the stop-low behaviour can be seen at the ports.

Top module: `pd_clock_sequencer`

## Requirements
- R1: After reset the block is in the running state: core_gate_en, ref_gate_en, vco_en and xtal_en are all 1.
- R2: pd_req_n passes through a two-flop synchronizer. If pd_req_n goes low before rising edge k, core_gate_en is still 1 after edge k+2 and is 0 after edge k+3.
- R3: core_gate_en changes only while clk is low, so core_clk_o = clk & core_gate_en never carries a shortened high pulse.
- R4: ref_clk_o is a square wave with a high phase of REF_HALF clk cycles. Its gate changes only when its phase is low, so every high pulse it shows lasts exactly REF_HALF cycles.
- R5: vco_en falls only after core_gate_en and ref_gate_en have both been 0 for at least GATE_LAT consecutive cycles.
- R6: xtal_en falls exactly one cycle after vco_en falls, and vco_en is never 1 while xtal_en is 0.
- R7: While vco_en is 0, both gates are closed and neither core_clk_o nor ref_clk_o has a rising edge.
- R8: On restart, vco_en rises exactly one cycle after xtal_en rises. core_gate_en reopens no earlier than STAB_CYCLES cycles after vco_en rises.
- R9: If pd_req_n is released while the block is asleep, core_gate_en is 1 within STAB_CYCLES+6 cycles and no sooner than STAB_CYCLES cycles.
- R10: If pd_req_n is released after the gates have closed but before sleep is reached, xtal_en still reaches 0 before core_gate_en reopens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal CPU clock; all sequencing runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| core_clk_o | output | 1 | Core clock group after gating |
| ref_clk_o | output | 1 | Modelled reference clock after gating |
| core_gate_en | output | 1 | Gate enable of the core clock group |
| ref_gate_en | output | 1 | Gate enable of the reference clock group |
| vco_en | output | 1 | VCO enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
The assertions check the ordering invariants on every cycle. These are: gates are closed whenever the VCO is off, the VCO is never on without the crystal, the crystal drops right after the VCO, the VCO rises right after the crystal, and the core gate waits out the stabilization window. The bench scenarios are needed for the rest: the synchronizer delay in exact cycles, the full width of every reference pulse, the wake latency bound measured from the pin, and the finish-then-restart order when a release lands mid-shutdown. Random request pulses of mixed lengths drive the sequencer through many partial and complete cycles.

// File: rtl/pdseq_pkg.sv
// Package: shared state encoding for the power-down sequencer.
// Assumes: one controller instance owns the state register.
package pdseq_pkg;
    typedef enum logic [2:0] {
        S_RUN     = 3'd0,
        S_PARK    = 3'd1,
        S_HOLD    = 3'd2,
        S_VCO_OFF = 3'd3,
        S_SLEEP   = 3'd4,
        S_XTAL_ON = 3'd5,
        S_STAB    = 3'd6
    } seq_state_t;
endpackage

// File: rtl/pdseq_sync.sv
// Module: brings the asynchronous active-low request into the clk domain
// through a STAGES-deep flop chain and presents it active-high.
// Assumes: STAGES >= 2; the chain resets to the "no request" level.
module pdseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_req_n,
    output logic req
);
    logic [STAGES-1:0] chain;

    // First stage captures the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= async_req_n;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Each further stage resolves metastability of the one before.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign req = ~chain[STAGES-1];
endmodule

// File: rtl/pdseq_core_gate.sv
// Module: falling-edge gate enable for the core clock group, so the
// gated clock stops and restarts only while clk is low.
// Assumes: gate_req comes from rising-edge logic in the same domain.
module pdseq_core_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_req,
    output logic gate_en,
    output logic gated_clk
);
    // Update the enable on the falling edge only.
    always_ff @(negedge clk) begin
        if (!rst_n) gate_en <= 1'b1;
        else        gate_en <= gate_req;
    end

    assign gated_clk = clk & gate_en;
endmodule

// File: rtl/pdseq_ref_gate.sv
// Module: models the free-running reference clock as a divided square wave
// (REF_HALF clk cycles per phase) and gates it only in its low phase.
// Assumes: the divider runs only while the crystal is enabled.
module pdseq_ref_gate #(
    parameter int REF_HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_run,
    input  logic gate_req,
    output logic gate_en,
    output logic ref_clk
);
    localparam int CW = $clog2(REF_HALF + 1);

    logic [CW-1:0] cnt, cnt_nxt;
    logic          ph, ph_nxt, wrap;

    // Next divider count and phase; both park at zero with the crystal off.
    always_comb begin
        wrap    = (cnt == CW'(REF_HALF - 1));
        cnt_nxt = osc_run ? (wrap ? '0 : cnt + 1'b1) : '0;
        ph_nxt  = osc_run ? (wrap ? ~ph : ph) : 1'b0;
    end

    // Divider state and a gate that may change only when the next phase is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            ph      <= 1'b0;
            gate_en <= 1'b1;
        end else begin
            cnt <= cnt_nxt;
            ph  <= ph_nxt;
            if (!ph_nxt) gate_en <= gate_req;
        end
    end

    assign ref_clk = ph & gate_en;
endmodule

// File: rtl/pdseq_ctrl.sv
// Module: shutdown / restart state machine. Shutdown: close gates, wait
// for both to be parked plus GATE_LAT cycles, drop VCO, then crystal.
// Restart: crystal, VCO, STAB_CYCLES wait, reopen gates.
// Assumes: GATE_LAT >= 1, STAB_CYCLES >= 1; a release is honoured only
// from the sleep state, so a started shutdown always completes.
module pdseq_ctrl
    import pdseq_pkg::*;
#(
    parameter int GATE_LAT    = 2,
    parameter int STAB_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic gates_parked,
    output logic gate_req,
    output logic vco_en,
    output logic xtal_en
);
    localparam int MAXC = (GATE_LAT > STAB_CYCLES) ? GATE_LAT : STAB_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;

    // Sequence state, wait counter and registered enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_RUN;
            cnt      <= '0;
            gate_req <= 1'b1;
            vco_en   <= 1'b1;
            xtal_en  <= 1'b1;
        end else begin
            case (state)
                S_RUN: begin
                    if (pd_req) begin
                        gate_req <= 1'b0;
                        state    <= S_PARK;
                    end
                end
                S_PARK: begin
                    if (gates_parked) begin
                        cnt   <= '0;
                        state <= S_HOLD;
                    end
                end
                S_HOLD: begin
                    if (cnt == CW'(GATE_LAT - 1)) begin
                        vco_en <= 1'b0;
                        state  <= S_VCO_OFF;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_VCO_OFF: begin
                    xtal_en <= 1'b0;
                    state   <= S_SLEEP;
                end
                S_SLEEP: begin
                    if (!pd_req) begin
                        xtal_en <= 1'b1;
                        state   <= S_XTAL_ON;
                    end
                end
                S_XTAL_ON: begin
                    vco_en <= 1'b1;
                    cnt    <= '0;
                    state  <= S_STAB;
                end
                S_STAB: begin
                    if (cnt == CW'(STAB_CYCLES - 1)) begin
                        gate_req <= 1'b1;
                        state    <= S_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= S_RUN;
            endcase
        end
    end
endmodule

// File: rtl/pd_clock_sequencer.sv
// Module: top of the power-down clock sequencer. Synchronizes the request,
// runs the shutdown/restart controller and drives the two gated groups.
// Assumes: clk is the internal CPU clock; reset is synchronous, active low.
module pd_clock_sequencer #(
    parameter int SYNC_STAGES = 2,
    parameter int GATE_LAT    = 2,
    parameter int STAB_CYCLES = 20,
    parameter int REF_HALF    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req_n,
    output logic core_clk_o,
    output logic ref_clk_o,
    output logic core_gate_en,
    output logic ref_gate_en,
    output logic vco_en,
    output logic xtal_en
);
    logic pd_req;
    logic gate_req;
    logic gates_parked;

    assign gates_parked = ~core_gate_en & ~ref_gate_en;

    pdseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .async_req_n (pd_req_n),
        .req         (pd_req)
    );

    pdseq_ctrl #(.GATE_LAT(GATE_LAT), .STAB_CYCLES(STAB_CYCLES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pd_req       (pd_req),
        .gates_parked (gates_parked),
        .gate_req     (gate_req),
        .vco_en       (vco_en),
        .xtal_en      (xtal_en)
    );

    pdseq_core_gate u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_req  (gate_req),
        .gate_en   (core_gate_en),
        .gated_clk (core_clk_o)
    );

    pdseq_ref_gate #(.REF_HALF(REF_HALF)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_run  (xtal_en),
        .gate_req (gate_req),
        .gate_en  (ref_gate_en),
        .ref_clk  (ref_clk_o)
    );
endmodule

// File: rtl/pdseq_checker.sv
// Module: ordering checks for the sequencer, bound to the top module.
// Assumes: sampled on the rising edge of clk; a saturating counter tracks
// how long the VCO has been on, so no check depends on a deep $past.
module pdseq_checker #(
    parameter int STAB_CYCLES = 20
) (
    input logic clk,
    input logic rst_n,
    input logic core_gate_en,
    input logic ref_gate_en,
    input logic vco_en,
    input logic xtal_en
);
    localparam int CW = $clog2(STAB_CYCLES + 2);

    logic [CW-1:0] since_vco;

    // Cycles since the VCO enable rose, saturating at STAB_CYCLES.
    always_ff @(posedge clk) begin
        if (!rst_n)                              since_vco <= '0;
        else if (!vco_en)                        since_vco <= '0;
        else if (since_vco < CW'(STAB_CYCLES))   since_vco <= since_vco + 1'b1;
    end

    AST_PARKED_BEFORE_VCO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vco_en) |-> $past(!core_gate_en && !ref_gate_en)); // R5
    AST_VCO_NEEDS_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
        !xtal_en |-> !vco_en); // R6
    AST_XTAL_AFTER_VCO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xtal_en) |-> $past(!vco_en)); // R6
    AST_GATES_SHUT_NO_VCO: assert property (@(posedge clk) disable iff (!rst_n)
        !vco_en |-> (!core_gate_en && !ref_gate_en)); // R7
    AST_VCO_FOLLOWS_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_en) |-> $past(xtal_en)); // R8
    AST_STAB_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_gate_en) |-> (since_vco >= CW'(STAB_CYCLES))); // R8
endmodule

bind pd_clock_sequencer pdseq_checker #(.STAB_CYCLES(STAB_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_gate_en (core_gate_en),
    .ref_gate_en  (ref_gate_en),
    .vco_en       (vco_en),
    .xtal_en      (xtal_en)
);

// File: tb/pd_clock_sequencer_bench.sv
module pd_clock_sequencer_bench;
    localparam int GATE_LAT = 2;
    localparam int STAB     = 20;
    localparam int REF_HALF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_req_n = 1'b1;
    logic core_clk_o, ref_clk_o, core_gate_en, ref_gate_en, vco_en, xtal_en;

    int  checks = 0;
    int  fails  = 0;
    bit  mon_on = 1'b0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    pd_clock_sequencer #(
        .SYNC_STAGES(2), .GATE_LAT(GATE_LAT), .STAB_CYCLES(STAB), .REF_HALF(REF_HALF)
    ) u_pd_clock_sequencer (
        .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n),
        .core_clk_o(core_clk_o), .ref_clk_o(ref_clk_o),
        .core_gate_en(core_gate_en), .ref_gate_en(ref_gate_en),
        .vco_en(vco_en), .xtal_en(xtal_en)
    );

    // Expected values derived from the requirements.
    function automatic int wake_max();
        return STAB + 6;
    endfunction
    function automatic int ref_high_len();
        return REF_HALF;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Cycle monitor sampled just after each rising edge.
    bit p_vco = 1, p_xtal = 1, p_core = 1, xtal_rose_prev = 0, vco_fell_prev = 0;
    int parked_run = 0, since_vco = 0;
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            chk(!(vco_en && !xtal_en), "R6", int'(vco_en), 0);
            if (p_vco && !vco_en) chk(parked_run >= GATE_LAT, "R5", parked_run, GATE_LAT);
            if (p_xtal && !xtal_en) chk(vco_fell_prev, "R6", int'(vco_fell_prev), 1);
            if (!p_vco && vco_en) chk(xtal_rose_prev, "R8", int'(xtal_rose_prev), 1);
            if (!p_core && core_gate_en) chk(since_vco >= STAB, "R8", since_vco, STAB);
            parked_run     = (!core_gate_en && !ref_gate_en) ? parked_run + 1 : 0;
            since_vco      = vco_en ? since_vco + 1 : 0;
            xtal_rose_prev = !p_xtal && xtal_en;
            vco_fell_prev  = p_vco && !vco_en;
            p_vco  = vco_en;
            p_xtal = xtal_en;
            p_core = core_gate_en;
        end
    end

    // R4: every visible reference high pulse has the full width.
    int hi_run = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (ref_clk_o) hi_run++;
            else if (hi_run > 0) begin
                chk(hi_run == ref_high_len(), "R4", hi_run, ref_high_len());
                hi_run = 0;
            end
        end
    end

    // R7: no gated clock edge while the VCO is off.
    always @(posedge core_clk_o or posedge ref_clk_o) begin
        if (mon_on) chk(vco_en, "R7", int'(vco_en), 1);
    end

    // R3: the core gate enable moves only while clk is low.
    always @(core_gate_en) begin
        if (mon_on) chk(clk === 1'b0, "R3", int'(clk), 0);
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int lat;
        bit saw_off;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk(core_gate_en == 1'b1, "R1", int'(core_gate_en), 1);
        chk(ref_gate_en == 1'b1, "R1", int'(ref_gate_en), 1);
        chk(vco_en == 1'b1, "R1", int'(vco_en), 1);
        chk(xtal_en == 1'b1, "R1", int'(xtal_en), 1);
        mon_on = 1'b1;
        repeat (10) @(posedge clk);

        // R2: synchronizer delay measured from the pin.
        @(negedge clk) pd_req_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(posedge clk); #1;
        chk(core_gate_en == 1'b1, "R2", int'(core_gate_en), 1);
        @(posedge clk); #1;
        chk(core_gate_en == 1'b0, "R2", int'(core_gate_en), 0);

        // R9: wake from sleep.
        wait (xtal_en == 1'b0);
        repeat (5) @(posedge clk);
        @(negedge clk) pd_req_n = 1'b1;
        lat = 0;
        do begin
            @(posedge clk); #1;
            lat++;
        end while (!core_gate_en && lat < 1000);
        chk(lat <= wake_max() && lat >= STAB, "R9", lat, wake_max());
        repeat (10) @(posedge clk);

        // R10: release right after the gates close.
        @(negedge clk) pd_req_n = 1'b0;
        wait (core_gate_en == 1'b0);
        @(negedge clk) pd_req_n = 1'b1;
        saw_off = 1'b0;
        lat = 0;
        do begin
            @(posedge clk); #1;
            if (!xtal_en) saw_off = 1'b1;
            lat++;
        end while (!core_gate_en && lat < 1000);
        chk(saw_off, "R10", int'(saw_off), 1);
        chk(core_gate_en == 1'b1, "R10", int'(core_gate_en), 1);

        // Random request pulses of mixed lengths.
        for (int i = 0; i < 40; i++) begin
            @(negedge clk) pd_req_n = 1'b0;
            repeat (1 + ($urandom % 80)) @(negedge clk);
            pd_req_n = 1'b1;
            repeat (1 + ($urandom % 80)) @(negedge clk);
        end
        repeat (STAB + 60) @(posedge clk);
        #1;
        chk(core_gate_en == 1'b1 && vco_en == 1'b1, "R9", int'(core_gate_en), 1);
        finish_run();
    end
endmodule